// File: doc/BRIEF.md
# Buffered SPI master with chip-select hold

This block is an SPI master that sends a group of queued words from a small local buffer. Software-side logic fills the buffer one entry at a time. Each entry holds a 32-bit data word, a chip-select number and a hold flag. A start pulse then sends entries 0 through a chosen last index. The character length is programmable, so only the right-aligned low bits of each word go out on the wire, most significant bit first. The bits clocked in on MISO land, right-aligned, in a receive buffer at the same index as the word that was sent.

Around every word the block runs a sequence: a chip-select setup delay, the data shift, a chip-select hold delay, and an inter-word gap. Each delay is counted in system clock cycles. A word whose hold flag is set opens a held frame. Every following word that names the same chip select is sent inside that frame without releasing chip select, whatever its own hold flag says. Inside a held frame the setup and hold delays are skipped, but the inter-word gap is still inserted. This lets a multi-byte command, such as an opcode followed by four data bytes, appear to the slave as one continuous chip-select-low frame.

Top module: `spi_grp_master`

## Requirements
- R1: During and right after reset, every `cs_n` bit is high, `sclk` and `mosi` are low, and `busy` and `done` are low.
- R2: A `start` pulse while idle sends buffer entries 0 to `grp_last` in index order. `busy` rises on the cycle after the pulse and stays high until `done`. A `start` pulse while busy has no effect: no extra word and no extra frame follows.
- R3: The shifted length L is `char_len` clamped to the range 2 to 16 (values below 2 give 2, values above 16 give 16). Only bits L-1..0 of the stored word are sent, most significant first. Higher bits have no effect on MOSI.
- R4: SPI mode 0. `sclk` idles low and each half period lasts `sclk_div`+1 clock cycles. MISO is sampled when `sclk` rises, and `mosi` changes only when `sclk` falls or when a word is loaded.
- R5: Once a word with the hold flag set has been sent, every following word in the group with the same chip-select number is sent without `cs_n` going high, regardless of those words' own hold flags.
- R6: Between two words where no hold is active, or where the chip-select number changes, `cs_n` goes high and then falls again.
- R7: Each extra unit of `setup_dly` lengthens the time from a `cs_n` fall to the first `sclk` rise by exactly one cycle. Between two words of a held frame, `setup_dly` has no effect.
- R8: Each extra unit of `hold_dly` lengthens the time from the last `sclk` fall of a frame to the `cs_n` rise by exactly one cycle. Between two words of a held frame, `hold_dly` has no effect.
- R9: Inside a held frame, each extra unit of `gap_dly` lengthens the time from a word's last `sclk` fall to the next word's first `sclk` rise by exactly one cycle.
- R10: The L received bits of word i are stored right-aligned, with zeros above, in receive entry i. `rd_data` shows entry `rd_addr` one clock after the address is applied.
- R11: `done` is a single-cycle pulse after the last word. While it is high, every `cs_n` bit is already high and `busy` is low.
- R12: At most one `cs_n` bit is low at any time. Chip-select number k drives bit k of `cs_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one buffer entry |
| wr_addr | input | AW | Buffer entry index to write |
| wr_data | input | 32 | Transmit word, right-aligned |
| wr_cs | input | CSW | Chip-select number for this entry |
| wr_hold | input | 1 | Hold flag for this entry |
| start | input | 1 | Begin sending the group |
| grp_last | input | AW | Index of the last entry in the group |
| char_len | input | 5 | Character length in bits |
| setup_dly | input | 8 | Cycles from chip-select fall to shift start |
| hold_dly | input | 8 | Cycles from shift end to chip-select release |
| gap_dly | input | 8 | Cycles between consecutive words |
| sclk_div | input | 8 | SCLK half period minus one, in clock cycles |
| busy | output | 1 | Group in progress |
| done | output | 1 | One-cycle pulse at the end of the group |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |
| rd_addr | input | AW | Receive buffer read index |
| rd_data | output | 16 | Receive buffer read data |

## Verification
The assertions assume that configuration inputs (`char_len`, the three delays, `sclk_div`) and the buffer contents stay constant while `busy` is high. They also assume that every stored chip-select number is below NCS. The stimulus changes configuration and writes entries only between groups, after `done`. It stores only chip-select numbers 0 and 1. Its MISO model changes the line only after it sees `sclk` fall, so every sampled bit is stable around the rising edge.

// File: rtl/spi_grp_pkg.sv
package spi_grp_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 5;
  localparam int DLY_W  = 8;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_FETCH, SQ_ARM, SQ_SETUP, SQ_SHIFT, SQ_HOLD, SQ_GAP, SQ_DONE
  } seq_st_t;
endpackage

// File: rtl/spi_grp_ram.sv
module spi_grp_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_grp_shift.sv
module spi_grp_shift
  import spi_grp_pkg::*;
#(
  parameter int MAX_LEN = 16,
  localparam int BW = $clog2(MAX_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [MAX_LEN-1:0] tx_word,
  input  logic [LEN_W-1:0]   nbits,
  input  logic [DLY_W-1:0]   presc,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               fin,
  output logic [MAX_LEN-1:0] rx_word
);
  logic               active;
  logic [DLY_W-1:0]   div;
  logic [MAX_LEN-1:0] tx_r;
  logic [BW-1:0]      bidx;
  logic [LEN_W-1:0]   nm1;
  logic [BW-1:0]      top_bit;

  assign nm1     = nbits - 1'b1;
  assign top_bit = nm1[BW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      div     <= '0;
      tx_r    <= '0;
      bidx    <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      fin     <= 1'b0;
      rx_word <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        active  <= 1'b1;
        div     <= '0;
        sclk    <= 1'b0;
        tx_r    <= tx_word;
        bidx    <= top_bit;
        mosi    <= tx_word[top_bit];
        rx_word <= '0;
      end else if (active) begin
        if (div == presc) begin
          div <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            rx_word <= {rx_word[MAX_LEN-2:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bidx == '0) begin
              active <= 1'b0;
              fin    <= 1'b1;
              mosi   <= 1'b0;
            end else begin
              bidx <= bidx - 1'b1;
              mosi <= tx_r[bidx-1'b1];
            end
          end
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  end

  assert_sclk_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sclk);
  assert_mosi_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(mosi) |-> ($fell(sclk) || $past(go)));
  assert_fin_after_fall_R4: assert property (@(posedge clk) disable iff (rst)
    fin |-> (!sclk && !active));
endmodule

// File: rtl/spi_grp_seq.sv
module spi_grp_seq
  import spi_grp_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NCS     = 2,
  parameter int MAX_LEN = 16,
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [AW-1:0]      grp_last,
  input  logic [MAX_LEN-1:0] ent_data,
  input  logic [CSW-1:0]     ent_cs,
  input  logic               ent_hold,
  input  logic [DLY_W-1:0]   setup_dly,
  input  logic [DLY_W-1:0]   hold_dly,
  input  logic [DLY_W-1:0]   gap_dly,
  input  logic               fin,
  input  logic [MAX_LEN-1:0] rx_word,
  output logic [AW-1:0]      rd_idx,
  output logic [MAX_LEN-1:0] tx_word,
  output logic               go,
  output logic               busy,
  output logic               done,
  output logic [NCS-1:0]     cs_n,
  output logic               rxw_en,
  output logic [AW-1:0]      rxw_addr,
  output logic [MAX_LEN-1:0] rxw_data
);
  seq_st_t          st;
  logic [AW-1:0]    idx, last;
  logic [DLY_W-1:0] cnt;
  logic [CSW-1:0]   cur_cs, w_cs;
  logic             w_hold, frame_open, hold_act, pend;

  assign rd_idx = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE; idx <= '0; last <= '0; cnt <= '0;
      cur_cs <= '0; w_cs <= '0; w_hold <= 1'b0; tx_word <= '0;
      frame_open <= 1'b0; hold_act <= 1'b0; pend <= 1'b0;
      go <= 1'b0; busy <= 1'b0; done <= 1'b0; cs_n <= '1;
      rxw_en <= 1'b0; rxw_addr <= '0; rxw_data <= '0;
    end else begin
      go     <= 1'b0;
      done   <= 1'b0;
      rxw_en <= 1'b0;
      unique case (st)
        SQ_IDLE: if (start) begin
          busy <= 1'b1; idx <= '0; last <= grp_last;
          frame_open <= 1'b0; hold_act <= 1'b0;
          st <= SQ_FETCH;
        end
        SQ_FETCH: st <= SQ_ARM;
        SQ_ARM: begin
          tx_word <= ent_data; w_cs <= ent_cs; w_hold <= ent_hold;
          if (frame_open && hold_act && ent_cs == cur_cs) begin
            cnt <= gap_dly; st <= SQ_GAP;
          end else if (frame_open) begin
            cnt <= hold_dly; pend <= 1'b1; st <= SQ_HOLD;
          end else begin
            cs_n <= ~(NCS'(1) << ent_cs); frame_open <= 1'b1;
            cur_cs <= ent_cs; hold_act <= ent_hold;
            cnt <= setup_dly; st <= SQ_SETUP;
          end
        end
        SQ_SETUP: if (cnt == '0) begin
          go <= 1'b1; st <= SQ_SHIFT;
        end else cnt <= cnt - 1'b1;
        SQ_SHIFT: if (fin) begin
          rxw_en <= 1'b1; rxw_addr <= idx; rxw_data <= rx_word;
          if (idx == last) begin
            cnt <= hold_dly; pend <= 1'b0; st <= SQ_HOLD;
          end else begin
            idx <= idx + 1'b1; st <= SQ_FETCH;
          end
        end
        SQ_HOLD: if (cnt == '0) begin
          cs_n <= '1; frame_open <= 1'b0; hold_act <= 1'b0;
          if (pend) begin cnt <= gap_dly; st <= SQ_GAP; end
          else st <= SQ_DONE;
        end else cnt <= cnt - 1'b1;
        SQ_GAP: if (cnt == '0) begin
          if (frame_open) begin
            go <= 1'b1; st <= SQ_SHIFT;
          end else begin
            cs_n <= ~(NCS'(1) << w_cs); frame_open <= 1'b1;
            cur_cs <= w_cs; hold_act <= w_hold;
            cnt <= setup_dly; st <= SQ_SETUP;
          end
        end else cnt <= cnt - 1'b1;
        SQ_DONE: begin
          done <= 1'b1; busy <= 1'b0; st <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_one_cs_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  assert_done_released_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> (&cs_n && !busy));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_held_frame_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_GAP && frame_open) |=> $stable(cs_n));
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && st != SQ_DONE) |=> busy);
endmodule

// File: rtl/spi_grp_master.sv
module spi_grp_master
  import spi_grp_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NCS     = 2,
  parameter int MAX_LEN = 16,
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [CSW-1:0]     wr_cs,
  input  logic               wr_hold,
  input  logic               start,
  input  logic [AW-1:0]      grp_last,
  input  logic [LEN_W-1:0]   char_len,
  input  logic [DLY_W-1:0]   setup_dly,
  input  logic [DLY_W-1:0]   hold_dly,
  input  logic [DLY_W-1:0]   gap_dly,
  input  logic [DLY_W-1:0]   sclk_div,
  output logic               busy,
  output logic               done,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [NCS-1:0]     cs_n,
  input  logic [AW-1:0]      rd_addr,
  output logic [MAX_LEN-1:0] rd_data
);
  localparam int ENT_W = 1 + CSW + MAX_LEN;

  logic [ENT_W-1:0]   ent;
  logic [AW-1:0]      rd_idx, rxw_addr;
  logic [MAX_LEN-1:0] tx_word, rx_word, rxw_data;
  logic [LEN_W-1:0]   eff_len;
  logic               go, fin, rxw_en;
  logic               unused_hi;

  assign unused_hi = ^wr_data[WORD_W-1:MAX_LEN];

  always_comb begin
    if (char_len < LEN_W'(2))            eff_len = LEN_W'(2);
    else if (char_len > LEN_W'(MAX_LEN)) eff_len = LEN_W'(MAX_LEN);
    else                                 eff_len = char_len;
  end

  spi_grp_ram #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_txbuf (
    .clk(clk), .we(wr_en), .waddr(wr_addr),
    .wdata({wr_hold, wr_cs, wr_data[MAX_LEN-1:0]}),
    .raddr(rd_idx), .rdata(ent));

  spi_grp_ram #(.WIDTH(MAX_LEN), .DEPTH(DEPTH)) u_rxbuf (
    .clk(clk), .we(rxw_en), .waddr(rxw_addr), .wdata(rxw_data),
    .raddr(rd_addr), .rdata(rd_data));

  spi_grp_seq #(.DEPTH(DEPTH), .NCS(NCS), .MAX_LEN(MAX_LEN)) u_seq (
    .clk(clk), .rst(rst), .start(start), .grp_last(grp_last),
    .ent_data(ent[MAX_LEN-1:0]), .ent_cs(ent[MAX_LEN +: CSW]),
    .ent_hold(ent[ENT_W-1]),
    .setup_dly(setup_dly), .hold_dly(hold_dly), .gap_dly(gap_dly),
    .fin(fin), .rx_word(rx_word), .rd_idx(rd_idx), .tx_word(tx_word),
    .go(go), .busy(busy), .done(done), .cs_n(cs_n),
    .rxw_en(rxw_en), .rxw_addr(rxw_addr), .rxw_data(rxw_data));

  spi_grp_shift #(.MAX_LEN(MAX_LEN)) u_shift (
    .clk(clk), .rst(rst), .go(go), .tx_word(tx_word), .nbits(eff_len),
    .presc(sclk_div), .miso(miso), .sclk(sclk), .mosi(mosi),
    .fin(fin), .rx_word(rx_word));

  assert_sclk_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk) |-> !(&cs_n));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (&cs_n && !sclk));
endmodule

// File: tb/spi_grp_master_bench.sv
module spi_grp_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int NCS = 2;
  localparam int MAX_LEN = 16;
  localparam int AW = 3;
  localparam int CSW = 1;

  logic clk, rst, wr_en, wr_hold, start, busy, done, sclk, mosi, miso;
  logic [AW-1:0] wr_addr, grp_last, rd_addr;
  logic [31:0] wr_data;
  logic [CSW-1:0] wr_cs;
  logic [4:0] char_len;
  logic [7:0] setup_dly, hold_dly, gap_dly, sclk_div;
  logic [NCS-1:0] cs_n;
  logic [MAX_LEN-1:0] rd_data;

  spi_grp_master #(.DEPTH(DEPTH), .NCS(NCS), .MAX_LEN(MAX_LEN)) u_spi_grp_master (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_cs(wr_cs), .wr_hold(wr_hold), .start(start), .grp_last(grp_last),
    .char_len(char_len), .setup_dly(setup_dly), .hold_dly(hold_dly),
    .gap_dly(gap_dly), .sclk_div(sclk_div), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .rd_addr(rd_addr), .rd_data(rd_data));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard state
  logic [15:0] exp_q[$];
  logic [15:0] rx_seen[DEPTH];
  logic [31:0] g_data[DEPTH];
  logic        g_cs[DEPTH];
  logic        g_hold[DEPTH];
  int eff_len = 8;
  int cyc = 0, frames = 0, mon_idx = 0, bitcnt = 0, frame_cs = 0;
  int t_csfall = 0, t_fall = 0, setup_iv = 0, hold_iv = 0, held_iv = 0, half_iv = 0;
  bit first_in_frame = 0;
  logic prev_sclk = 0;
  logic [NCS-1:0] prev_csn = '1;
  logic [15:0] mo = 0, mi = 0;
  logic [31:0] lfsr = 32'hACE1_2B37;

  // monitor: observes the wire and pops expected words
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if ((&prev_csn) && !(&cs_n)) begin
        frames++; t_csfall = cyc; first_in_frame = 1;
        frame_cs = cs_n[0] ? 1 : 0;
      end
      if (!(&prev_csn) && (&cs_n)) hold_iv = cyc - t_fall;
      if (!prev_sclk && sclk) begin
        if (first_in_frame) begin setup_iv = cyc - t_csfall; first_in_frame = 0; end
        else if (bitcnt == 0) held_iv = cyc - t_fall;
        else half_iv = cyc - t_fall;
        mo = {mo[14:0], mosi};
        mi = {mi[14:0], miso};
        bitcnt++;
        if (bitcnt == eff_len) begin
          if (exp_q.size() == 0) chk(0, "R2", "unexpected word", 32'(mo), 0);
          else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(mo == e, "R3", "MOSI word", 32'(mo), 32'(e));
          end
          if (mon_idx < DEPTH) rx_seen[mon_idx] = mi;
          mon_idx++; bitcnt = 0; mo = 0; mi = 0;
        end
      end
      if (prev_sclk && !sclk) begin
        t_fall = cyc;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        miso = lfsr[0];
      end
    end
    prev_sclk = sclk;
    prev_csn = cs_n;
  end

  function automatic int clamp_len(input int l);
    return (l < 2) ? 2 : (l > 16) ? 16 : l;
  endfunction

  // driver: loads entries, pushes expected words, runs one group
  task automatic send(input int n, input bit poke);
    logic [31:0] mask;
    int guard;
    eff_len = clamp_len(int'(char_len));
    mask = (32'd1 << eff_len) - 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1; wr_addr = AW'(i); wr_data = g_data[i];
      wr_cs = g_cs[i]; wr_hold = g_hold[i];
      exp_q.push_back(16'(g_data[i] & mask));
    end
    @(negedge clk);
    wr_en = 0; frames = 0; mon_idx = 0;
    grp_last = AW'(n - 1); start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R2", "busy after start", 32'(busy), 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      grp_last = AW'(DEPTH - 1); start = 1;
      @(negedge clk);
      start = 0;
    end
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R11", "done seen", 32'(done), 1);
    chk(&cs_n, "R11", "cs released at done", 32'(cs_n), 32'(2**NCS - 1));
    chk(busy == 1'b0, "R11", "busy low at done", 32'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", 32'(done), 0);
    chk(exp_q.size() == 0, "R2", "words left unsent", 32'(exp_q.size()), 0);
    for (int i = 0; i < n; i++) begin
      rd_addr = AW'(i);
      @(negedge clk);
      chk(rd_data == rx_seen[i], "R10", "receive entry", 32'(rd_data), 32'(rx_seen[i]));
    end
  endtask

  task automatic cfg(input int len, input int s, input int h, input int g, input int p);
    char_len = 5'(len); setup_dly = 8'(s); hold_dly = 8'(h);
    gap_dly = 8'(g); sclk_div = 8'(p);
  endtask

  task automatic fill_frame5;
    g_data[0] = 32'hDEAD_BE9C; g_data[1] = 32'h1234_5601; g_data[2] = 32'hFFFF_FF7E;
    g_data[3] = 32'h0F0F_0FA5; g_data[4] = 32'h8000_003C;
    for (int i = 0; i < 5; i++) begin g_cs[i] = 0; g_hold[i] = (i == 0); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int s0, h0, g0;
    rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; wr_cs = 0; wr_hold = 0;
    start = 0; grp_last = 0; rd_addr = 0; miso = 0;
    cfg(8, 3, 4, 2, 1);
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(&cs_n, "R1", "cs_n in reset", 32'(cs_n), 3);
    chk(!sclk && !mosi, "R1", "sclk/mosi in reset", {30'd0, sclk, mosi}, 0);
    chk(!busy && !done, "R1", "busy/done in reset", {30'd0, busy, done}, 0);
    rst = 0;
    @(negedge clk);
    chk(&cs_n && !busy, "R1", "idle after reset", 32'(cs_n), 3);

    // R5: opcode + four bytes, hold on first word only, one frame
    fill_frame5();
    send(5, 0);
    chk(frames == 1, "R5", "held frame count", frames, 1);
    chk(half_iv == 2, "R4", "half period div=1", half_iv, 2);
    s0 = setup_iv; h0 = hold_iv; g0 = held_iv;

    // R7 R8: larger setup/hold change frame edges but not held boundaries
    cfg(8, 10, 10, 2, 1);
    fill_frame5();
    send(5, 0);
    chk(setup_iv == s0 + 7, "R7", "setup interval", setup_iv, s0 + 7);
    chk(hold_iv == h0 + 6, "R8", "hold interval", hold_iv, h0 + 6);
    chk(held_iv == g0, "R7", "held boundary unaffected by setup/hold", held_iv, g0);

    // R9: gap still inserted in held frame
    cfg(8, 3, 4, 7, 1);
    fill_frame5();
    send(5, 0);
    chk(held_iv == g0 + 5, "R9", "gap interval", held_iv, g0 + 5);

    // R6 + R2: no hold, three frames; start while busy ignored
    cfg(8, 1, 1, 1, 1);
    for (int i = 0; i < 3; i++) begin
      g_data[i] = 32'h5A00 + i * 32'h13; g_cs[i] = 0; g_hold[i] = 0;
    end
    send(3, 1);
    repeat (60) @(negedge clk);
    chk(frames == 3, "R6", "frames without hold", frames, 3);
    chk(mon_idx == 3, "R2", "no words after ignored start", mon_idx, 3);

    // R12 + R6: chip-select change closes a held frame
    cfg(8, 2, 2, 2, 0);
    g_data[0] = 32'hC3; g_cs[0] = 0; g_hold[0] = 1;
    g_data[1] = 32'h81; g_cs[1] = 1; g_hold[1] = 1;
    g_data[2] = 32'h7E; g_cs[2] = 1; g_hold[2] = 0;
    g_data[3] = 32'h42; g_cs[3] = 1; g_hold[3] = 0;
    send(4, 0);
    chk(frames == 2, "R12", "frames with cs change", frames, 2);
    chk(frame_cs == 1, "R12", "second frame uses cs1", frame_cs, 1);

    // R3: other lengths, MSB first, clamp; R4 prescaler
    cfg(12, 0, 0, 0, 3);
    for (int i = 0; i < 3; i++) begin
      g_data[i] = 32'hFFFF_0000 | (32'hA5C + i * 32'h111); g_cs[i] = 1; g_hold[i] = 1;
    end
    send(3, 0);
    chk(half_iv == 4, "R4", "half period div=3", half_iv, 4);
    chk(frames == 1, "R5", "12-bit held frame", frames, 1);
    cfg(25, 1, 1, 1, 0);
    g_data[0] = 32'h1234_BEEF; g_cs[0] = 0; g_hold[0] = 0;
    g_data[1] = 32'hFFFF_8001; g_cs[0] = 0; g_hold[1] = 0; g_cs[1] = 0;
    send(2, 0);
    chk(eff_len == 16, "R3", "clamp high", eff_len, 16);
    cfg(1, 1, 1, 1, 0);
    g_data[0] = 32'hFFFF_FFF6; g_cs[0] = 0; g_hold[0] = 0;
    send(1, 0);
    chk(frames == 1, "R3", "2-bit word frame", frames, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule